// File: doc/BRIEF.md
# Processor-bus serial port

This block is a byte-wide asynchronous serial port for a small processor. The processor reaches it through one shared bidirectional 8-bit data bus, qualified by a chip select, a read/write-bar strobe and a 2-bit register address. One transmit byte and one received byte are buffered. Two plain handshake outputs tell the processor when it may write a new byte and when a received byte is waiting.

A programmable divisor, loaded over the bus at run time, sets the rate of a sampling enable that runs at sixteen times the bit rate. The same standard rates can therefore be kept across different system clocks. With the reset divisor of 33, a 5 MHz clock gives about 9600 bit/s. A frame is one low start bit, eight data bits sent least significant first, an optional even or odd parity bit, and one high stop bit. A pin selects the parity mode, and the same setting applies in both directions.

The processor side is a register bus, not a stream, so there is no valid/ready pair. The flow-control rule is the handshake itself. The processor writes a byte only while `tx_ready` is high, and it reads a byte once `rx_avail` rises. A byte that is not read before the next frame completes is replaced by that frame.

Top module: `serp_core`

## Requirements
- R1: After reset, `txd` is 1, `tx_ready` is 1, `rx_avail` is 0, and the divisor is the `DIV_RESET` parameter (default 33, read back as low byte 8'h21 and high byte 8'h00).
- R2: The register address selects one of four registers.
  - 2'b00 is the data register: a write sends a byte, and a read returns the last received byte.
  - 2'b01 is the read-only status register: bit 0 is tx_ready, bit 1 is rx_avail, bit 2 is framing error, bit 3 is parity error, and bits 7:4 are 0.
  - 2'b10 is the divisor low byte and 2'b11 is the divisor high byte; both can be read and written.
  - `data` is driven only while `cs`=1 and `rw_n`=1. At all other times it is high impedance.
- R3: Writing either divisor byte restarts the rate counter at once. The sampling enable then occurs every max(divisor,1) clocks, and one bit lasts 16 enables, so the first (start) bit lasts between 15*div and 16*div clocks.
- R4: A data write accepted while tx_ready=1 makes `txd` go low (start bit) on the next clock. The eight data bits follow least significant first, and then a stop bit at 1.
- R5: The `par_mode` pin selects the parity mode.
  - 2'b00 and 2'b11 mean no parity bit.
  - 2'b01 means even parity: the parity bit makes the count of ones over data and parity even.
  - 2'b10 means odd parity: the count of ones over data and parity is odd.
  - In these modes the parity bit sits between the data bits and the stop bit.
- R6: tx_ready goes to 0 on the clock after an accepted write and stays 0 until the stop bit has been sent. A data write made while tx_ready=0 is ignored: no extra frame is sent.
- R7: While nothing is being sent, `txd` stays at 1.
- R8: RxD passes through a resynchronizing flip-flop chain (SYNC_STAGES, default 2) before use. A complete frame, received least significant bit first, sets rx_avail, and the byte can then be read from register 2'b00.
- R9: Reading register 2'b00 clears rx_avail. A frame completing in the same cycle keeps it set.
- R10: The start bit is checked again at the 8th sample. If RxD has returned high by then, the frame is dropped: rx_avail does not rise, and the next real frame is received correctly.
- R11: A stop bit sampled low sets status bit 2 for that frame. The byte is still delivered, and the next good frame clears the bit.
- R12: With parity enabled, a received parity bit that does not match sets status bit 3. The byte is still delivered, and a frame with correct parity clears the bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, qualifies a bus access |
| rw_n | input | 1 | 1 = read, 0 = write |
| addr | input | 2 | Register select |
| data | inout | 8 | Shared bidirectional data bus |
| par_mode | input | 2 | Parity mode select |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| tx_ready | output | 1 | Transmit buffer empty, a write is accepted |
| rx_avail | output | 1 | Received byte waiting |

## Verification
The transmitter is driven with bytes that have asymmetric bit patterns (8'hA5, 8'h01, 8'h07) and is checked by a line decoder. A wrong bit order or a misplaced bit shows up as a changed value, and 8'h07 under even and then odd parity tells the two parity senses apart. The width of a start bit followed by a 1 data bit is measured at two divisors, which shows that the divisor reload takes effect. The receiver is fed, in turn:
- a clean frame;
- a frame with the wrong parity bit;
- a frame with a low stop bit;
- a short low glitch.

These patterns separate correct delivery, each error flag, and the mid-start rejection. A second data write during a frame shows that writes made while the transmitter is busy are dropped.

// File: rtl/serp_pkg.sv
package serp_pkg;
  localparam int DIV_W = 16;
  localparam int FRAME_MAX = 11;

  typedef enum logic [1:0] {
    ADR_DATA = 2'b00,
    ADR_STAT = 2'b01,
    ADR_DLO  = 2'b10,
    ADR_DHI  = 2'b11
  } reg_adr_e;

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_EVEN = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_RSVD = 2'b11
  } par_e;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP
  } rx_st_e;
endpackage

// File: rtl/serp_baud.sv
module serp_baud
  import serp_pkg::*;
#(
  parameter logic [DIV_W-1:0] DIV_RESET = 16'd33
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [7:0]       wbyte,
  output logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] div_nxt;
  logic [DIV_W-1:0] reload;

  always_comb begin
    div_nxt = divisor;
    if (wr_lo) div_nxt[7:0] = wbyte;
    if (wr_hi) div_nxt[15:8] = wbyte;
    reload = (div_nxt == '0) ? '0 : div_nxt - 1'b1;
  end

  assign tick = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divisor <= DIV_RESET;
      cnt     <= (DIV_RESET == '0) ? '0 : DIV_RESET - 1'b1;
    end else begin
      divisor <= div_nxt;
      if (wr_lo || wr_hi || cnt == '0) cnt <= reload;
      else                             cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/serp_tx.sv
module serp_tx
  import serp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       load,
  input  logic [7:0] din,
  input  par_e       pmode,
  output logic       txd,
  output logic       ready
);
  logic [FRAME_MAX-1:0] shreg;
  logic [3:0]           bits_left;
  logic [3:0]           sub;
  logic                 busy;
  logic                 par_on;
  logic                 pbit;

  assign par_on = (pmode == PAR_EVEN) || (pmode == PAR_ODD);
  assign pbit   = (^din) ^ (pmode == PAR_ODD);
  assign txd    = busy ? shreg[0] : 1'b1;
  assign ready  = !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '1;
      bits_left <= '0;
      sub       <= '0;
      busy      <= 1'b0;
    end else if (!busy) begin
      if (load) begin
        busy <= 1'b1;
        sub  <= '0;
        if (par_on) begin
          shreg     <= {1'b1, pbit, din, 1'b0};
          bits_left <= 4'd11;
        end else begin
          shreg     <= {2'b11, din, 1'b0};
          bits_left <= 4'd10;
        end
      end
    end else if (tick) begin
      if (sub == 4'd15) begin
        sub       <= '0;
        shreg     <= {1'b1, shreg[FRAME_MAX-1:1]};
        bits_left <= bits_left - 1'b1;
        if (bits_left == 4'd1) busy <= 1'b0;
      end else begin
        sub <= sub + 1'b1;
      end
    end
  end
endmodule

// File: rtl/serp_rx.sv
module serp_rx
  import serp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd_raw,
  input  par_e       pmode,
  output logic [7:0] dout,
  output logic       done,
  output logic       ferr,
  output logic       perr
);
  localparam int NS = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [NS-1:0] sync;
  logic          rxs;
  rx_st_e        st;
  logic [3:0]    cnt;
  logic [2:0]    nbit;
  logic [7:0]    sh;
  logic          last;
  logic          pbit;
  logic          par_on;

  assign rxs    = sync[NS-1];
  assign par_on = (pmode == PAR_EVEN) || (pmode == PAR_ODD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= '1;
    else        sync <= {sync[NS-2:0], rxd_raw};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= RX_IDLE;
      cnt  <= '0;
      nbit <= '0;
      sh   <= '0;
      last <= 1'b1;
      pbit <= 1'b0;
      dout <= '0;
      done <= 1'b0;
      ferr <= 1'b0;
      perr <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        last <= rxs;
        unique case (st)
          RX_IDLE: if (last && !rxs) begin
            st  <= RX_START;
            cnt <= 4'd1;
          end
          RX_START: begin
            if (cnt == 4'd7) begin
              cnt  <= '0;
              nbit <= '0;
              st   <= rxs ? RX_IDLE : RX_DATA;
            end else cnt <= cnt + 1'b1;
          end
          RX_DATA: begin
            if (cnt == 4'd15) begin
              cnt  <= '0;
              sh   <= {rxs, sh[7:1]};
              nbit <= nbit + 1'b1;
              if (nbit == 3'd7) st <= par_on ? RX_PAR : RX_STOP;
            end else cnt <= cnt + 1'b1;
          end
          RX_PAR: begin
            if (cnt == 4'd15) begin
              cnt  <= '0;
              pbit <= rxs;
              st   <= RX_STOP;
            end else cnt <= cnt + 1'b1;
          end
          RX_STOP: begin
            if (cnt == 4'd15) begin
              cnt  <= '0;
              done <= 1'b1;
              dout <= sh;
              ferr <= !rxs;
              perr <= par_on && (pbit != ((^sh) ^ (pmode == PAR_ODD)));
              st   <= RX_IDLE;
            end else cnt <= cnt + 1'b1;
          end
          default: st <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/serp_core.sv
module serp_core
  import serp_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter logic [DIV_W-1:0] DIV_RESET   = 16'd33
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs,
  input  logic       rw_n,
  input  logic [1:0] addr,
  inout  wire  [7:0] data,
  input  logic [1:0] par_mode,
  input  logic       rxd,
  output logic       txd,
  output logic       tx_ready,
  output logic       rx_avail
);
  logic             bus_wr;
  logic             bus_rd;
  logic             tick;
  logic [DIV_W-1:0] divisor;
  logic [7:0]       rx_byte;
  logic             rx_done;
  logic             ferr;
  logic             perr;
  logic [7:0]       rdata;
  par_e             pmode;

  assign pmode  = par_e'(par_mode);
  assign bus_wr = cs && !rw_n;
  assign bus_rd = cs && rw_n;

  serp_baud #(.DIV_RESET(DIV_RESET)) u_baud (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_lo   (bus_wr && addr == ADR_DLO),
    .wr_hi   (bus_wr && addr == ADR_DHI),
    .wbyte   (data),
    .divisor (divisor),
    .tick    (tick)
  );

  serp_tx u_tx (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .load  (bus_wr && addr == ADR_DATA),
    .din   (data),
    .pmode (pmode),
    .txd   (txd),
    .ready (tx_ready)
  );

  serp_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .rxd_raw (rxd),
    .pmode   (pmode),
    .dout    (rx_byte),
    .done    (rx_done),
    .ferr    (ferr),
    .perr    (perr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               rx_avail <= 1'b0;
    else if (rx_done)                         rx_avail <= 1'b1;
    else if (bus_rd && addr == ADR_DATA)      rx_avail <= 1'b0;
  end

  always_comb begin
    unique case (reg_adr_e'(addr))
      ADR_DATA: rdata = rx_byte;
      ADR_STAT: rdata = {4'b0, perr, ferr, rx_avail, tx_ready};
      ADR_DLO:  rdata = divisor[7:0];
      ADR_DHI:  rdata = divisor[15:8];
      default:  rdata = '0;
    endcase
  end

  assign data = bus_rd ? rdata : 8'hzz;
endmodule

// File: rtl/serp_core_chk.sv
module serp_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs,
  input logic       rw_n,
  input logic [1:0] addr,
  input logic       txd,
  input logic       tx_ready,
  input logic       rx_avail,
  input logic       rx_done
);
  AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> txd); // R7

  AST_LOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !rw_n && addr == 2'b00 && tx_ready) |=> (!txd && !tx_ready)); // R4

  AST_RDA_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rw_n && addr == 2'b00 && !rx_done) |=> !rx_avail); // R9

  AST_RDA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_avail && !(cs && rw_n && addr == 2'b00)) |=> rx_avail); // R8

  AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> rx_avail); // R9
endmodule

bind serp_core serp_core_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs       (cs),
  .rw_n     (rw_n),
  .addr     (addr),
  .txd      (txd),
  .tx_ready (tx_ready),
  .rx_avail (rx_avail),
  .rx_done  (rx_done)
);

// File: tb/serp_core_test.sv
module serp_core_test;
  localparam int P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0;
  logic       rw_n = 1'b1;
  logic [1:0] addr = 2'b00;
  logic [1:0] par_mode = 2'b00;
  logic       rxd = 1'b1;
  logic       txd, tx_ready, rx_avail;
  logic       drv = 1'b0;
  logic [7:0] dval = 8'h00;
  wire  [7:0] data;

  int tests = 0;
  int fails = 0;
  int div_now = 33;
  int tx_frames = 0;
  logic [7:0] txq[$];

  assign data = drv ? dval : 8'hzz;

  serp_core uut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rw_n(rw_n), .addr(addr),
    .data(data), .par_mode(par_mode), .rxd(rxd), .txd(txd),
    .tx_ready(tx_ready), .rx_avail(rx_avail)
  );

  always #(P/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    tests++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] v);
    @(negedge clk);
    cs = 1'b1; rw_n = 1'b0; addr = a; dval = v; drv = 1'b1;
    @(negedge clk);
    cs = 1'b0; rw_n = 1'b1; drv = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    cs = 1'b1; rw_n = 1'b1; addr = a;
    #(P/4) v = data;
    @(negedge clk);
    cs = 1'b0;
  endtask

  // driver: queues the expected line byte, then writes it
  task automatic tx_send(input logic [7:0] v);
    txq.push_back(v);
    bus_write(2'b00, v);
  endtask

  task automatic set_div(input int d);
    bus_write(2'b10, d[7:0]);
    bus_write(2'b11, d[15:8]);
    div_now = d;
  endtask

  task automatic line_bit(input logic b);
    rxd = b;
    repeat (16 * div_now) @(negedge clk);
  endtask

  task automatic rx_send(input logic [7:0] v, input logic bad_par, input logic bad_stop);
    @(negedge clk);
    line_bit(1'b0);
    for (int i = 0; i < 8; i++) line_bit(v[i]);
    if (par_mode == 2'b01 || par_mode == 2'b10)
      line_bit((^v) ^ (par_mode == 2'b10) ^ bad_par);
    line_bit(!bad_stop);
    rxd = 1'b1;
    repeat (16 * div_now) @(negedge clk);
  endtask

  task automatic wait_tx_idle;
    while (tx_ready !== 1'b1) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // monitor: decodes txd frames and compares against the queue
  initial begin
    @(posedge rst_n);
    forever begin
      logic [7:0] got;
      logic [7:0] exp;
      logic pb;
      @(negedge txd);
      #(16 * div_now * P / 2);
      chk("R4 start bit", txd, 0);
      for (int i = 0; i < 8; i++) begin
        #(16 * div_now * P);
        got[i] = txd;
      end
      if (par_mode == 2'b01 || par_mode == 2'b10) begin
        #(16 * div_now * P);
        pb = txd;
        chk("R5 parity bit", pb, (^got) ^ (par_mode == 2'b10));
      end
      #(16 * div_now * P);
      chk("R4 stop bit", txd, 1);
      tx_frames++;
      if (txq.size() == 0) begin
        tests++; fails++;
        $display("FAIL R6: got unexpected frame %0h expected none", got);
      end else begin
        exp = txq.pop_front();
        chk("R4 frame data", got, exp);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 txd", txd, 1);
    chk("R1 tx_ready", tx_ready, 1);
    chk("R1 rx_avail", rx_avail, 0);
    bus_read(2'b01, v); chk("R2 status reset", v, 8'h01);
    bus_read(2'b10, v); chk("R1 div low", v, 8'h21);
    bus_read(2'b11, v); chk("R1 div high", v, 8'h00);
    #(P/4);
    chk("R2 bus released", (data === 8'hzz), 1);

    set_div(4);
    bus_read(2'b10, v); chk("R2 div low readback", v, 8'h04);

    // TX no parity, busy write ignored
    tx_send(8'hA5);
    chk("R6 tx_ready low", tx_ready, 0);
    bus_write(2'b00, 8'h3C);
    wait_tx_idle();
    repeat (16 * 4 * 2) @(negedge clk);
    chk("R6 one frame only", tx_frames, 1);
    chk("R7 idle high", txd, 1);

    // start-bit width at divisor 4
    tx_send(8'h01);
    w = 0;
    while (txd === 1'b0) begin @(negedge clk); w++; end
    chk_rng("R3 bit width div4", w, 15 * 4, 16 * 4 + 1);
    wait_tx_idle();

    // parity modes
    par_mode = 2'b01; tx_send(8'h07); wait_tx_idle();
    par_mode = 2'b10; tx_send(8'h07); wait_tx_idle();
    repeat (16 * 4) @(negedge clk);
    chk("R5 frames sent", tx_frames, 4);

    // RX clean, no parity
    par_mode = 2'b00;
    rx_send(8'h5A, 1'b0, 1'b0);
    chk("R8 rx_avail set", rx_avail, 1);
    bus_read(2'b01, v); chk("R2 status rx", v, 8'h03);
    bus_read(2'b00, v); chk("R8 rx data", v, 8'h5A);
    chk("R9 rx_avail cleared", rx_avail, 0);

    // RX even parity good then bad
    par_mode = 2'b01;
    rx_send(8'h81, 1'b0, 1'b0);
    bus_read(2'b01, v); chk("R12 parity ok", v, 8'h03);
    bus_read(2'b00, v); chk("R8 rx even data", v, 8'h81);
    rx_send(8'h81, 1'b1, 1'b0);
    bus_read(2'b01, v); chk("R12 parity error flag", v, 8'h0B);
    bus_read(2'b00, v); chk("R12 data still delivered", v, 8'h81);
    par_mode = 2'b10;
    rx_send(8'h96, 1'b0, 1'b0);
    bus_read(2'b01, v); chk("R12 odd ok clears flag", v, 8'h03);
    bus_read(2'b00, v); chk("R8 rx odd data", v, 8'h96);

    // framing error
    par_mode = 2'b00;
    rx_send(8'h3E, 1'b0, 1'b1);
    bus_read(2'b01, v); chk("R11 framing flag", v, 8'h07);
    bus_read(2'b00, v); chk("R11 data delivered", v, 8'h3E);
    repeat (16 * 4 * 2) @(negedge clk);
    rx_send(8'h11, 1'b0, 1'b0);
    bus_read(2'b01, v); chk("R11 flag cleared", v, 8'h03);
    bus_read(2'b00, v); chk("R8 rx after ferr", v, 8'h11);

    // start glitch
    @(negedge clk);
    rxd = 1'b0;
    repeat (12) @(negedge clk);
    rxd = 1'b1;
    repeat (16 * 4 * 12) @(negedge clk);
    chk("R10 glitch rejected", rx_avail, 0);
    rx_send(8'hE7, 1'b0, 1'b0);
    bus_read(2'b00, v); chk("R10 next frame ok", v, 8'hE7);

    // new divisor
    set_div(8);
    tx_send(8'h01);
    w = 0;
    while (txd === 1'b0) begin @(negedge clk); w++; end
    chk_rng("R3 bit width div8", w, 15 * 8, 16 * 8 + 1);
    wait_tx_idle();
    repeat (16 * 8) @(negedge clk);
    chk("R3 frame at div8", tx_frames, 5);
    rx_send(8'hC3, 1'b0, 1'b0);
    bus_read(2'b00, v); chk("R3 rx at div8", v, 8'hC3);
    chk("R4 queue drained", txq.size(), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule